// File: doc/BRIEF.md
# Width-Speculating Execute Slice

This block is the execute stage of a datapath that runs in one of three widths: 8, 16 or 32 bits. Software chooses the width with a reconfiguration command at the start of each code region. The block does not detect narrow operands by itself. It executes each operation at the width last chosen and checks afterwards whether that choice was safe. The ALU and result latches are divided into three slices: bits 7:0, bits 15:8 and bits 31:16. Slices that the current width does not need are clock-enabled off, and the register-file slices behind them are asked to go drowsy.

When an operand or the result does not fit the speculated width, the block drops the result and raises a one-cycle flush request. It then stalls for a fixed penalty and replays the offending operation internally at full width. After a replay the block stays at full width until software issues its next reconfiguration command. Waking drowsy slices for a wider width costs one stall cycle.

Top module: `nwx_exec_slice`

## Requirements
- R1: Width codes on `cfg_mode` are 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. `slice_en` bit 0 covers bits 7:0, bit 1 covers bits 15:8 and bit 2 covers bits 31:16. The enabled pattern is 3'b001, 3'b011 and 3'b111 for the three widths. Out of reset the width is 32-bit, `slice_en` = 3'b111, and `res_valid`, `res_data`, `flush_req` and `stall` are all 0.
- R2: `drowsy` is always the bitwise complement of `slice_en`.
- R3: A reconfiguration is taken when `cfg_valid` is high and `stall` is low, and it takes effect in the next cycle. An operation taken in the same cycle executes at the previous width.
- R4: A reconfiguration that enables a slice which was off raises `stall` for exactly one cycle, the cycle after it is taken. A reconfiguration that narrows the width causes no stall.
- R5: An operation is taken when `op_valid` is high and `stall` is low. Opcodes are 0 = a+b, 1 = a−b, 2 = a&b, 3 = a|b, 4 = a^b, and 5 to 7 = pass a. Arithmetic wraps modulo 2^32. A fitting result appears on `res_data` with `res_valid` high in the cycle after the operation is taken.
- R6: A 32-bit value fits width W (8 or 16) when bits 31:W are all zero, or when bits 31:W−1 are all one. The rule is applied to a, b and the full result. Every value fits width 32.
- R7: When a taken operation does not fit, the next cycle has `res_valid` low and `flush_req` high for one cycle. `stall` is high for REPLAY_PENALTY cycles starting with the flush cycle.
- R8: The replayed operation's correct 32-bit result appears with `res_valid` high REPLAY_PENALTY cycles after the flush cycle, in the same cycle that `stall` falls.
- R9: `slice_en` is 3'b111 throughout the penalty. After a replay the width remains 32-bit until the next reconfiguration is taken.
- R10: If a reconfiguration is taken in the same cycle as a misfitting operation, the replay still runs at full width. After the replay, the width is the one that reconfiguration requested.
- R11: Operations and reconfigurations presented while `stall` is high are ignored. They produce no result and do not change the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Reconfiguration command present |
| cfg_mode | input | 2 | Requested width code |
| op_valid | input | 1 | Operation present |
| op_code | input | 3 | ALU function |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| res_valid | output | 1 | Result on `res_data` is valid |
| res_data | output | 32 | Result |
| slice_en | output | 3 | Active datapath slices |
| drowsy | output | 3 | Low-power request per register-file slice |
| flush_req | output | 1 | Misspeculation flush pulse |
| stall | output | 1 | Block accepts no new work |

## Verification
The interesting overlap is a reconfiguration that arrives in the same cycle as an operation which misfits the old width. In that cycle two things compete for the width register: the forced return to full width and the width software requested. The bench provokes this from 8-bit mode with a 16-bit request and an operand of 0x100. It judges the outcome on three counts: the operation must flush because it ran at the old width, the replayed result must be correct, and `slice_en` must read 3'b011 once the stall ends. A second case pairs a narrowing request with a fitting operation at 32-bit width, and the bench expects the result to come through unharmed.

// File: rtl/nwx_pkg.sv
package nwx_pkg;
  localparam int SLICE_W0 = 8;
  localparam int SLICE_W1 = 8;
  localparam int SLICE_W2 = 16;
  localparam int NSLICE   = 3;
  localparam int DW       = SLICE_W0 + SLICE_W1 + SLICE_W2;
  localparam int NW8      = SLICE_W0;
  localparam int NW16     = SLICE_W0 + SLICE_W1;

  typedef enum logic [1:0] {
    MODE_B8  = 2'd0,
    MODE_B16 = 2'd1,
    MODE_B32 = 2'd2,
    MODE_RSV = 2'd3
  } nwx_mode_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } nwx_op_e;

  function automatic int slice_lo(int idx);
    return (idx == 0) ? 0 : (idx == 1) ? SLICE_W0 : SLICE_W0 + SLICE_W1;
  endfunction

  function automatic int slice_w(int idx);
    return (idx == 0) ? SLICE_W0 : (idx == 1) ? SLICE_W1 : SLICE_W2;
  endfunction

  function automatic logic [NSLICE-1:0] mode_mask(logic [1:0] m);
    case (m)
      MODE_B8:  return 3'b001;
      MODE_B16: return 3'b011;
      default:  return 3'b111;
    endcase
  endfunction

  // A value fits a narrow width when its upper part is a zero- or sign-extension.
  function automatic logic fits_width(logic [DW-1:0] v, logic [1:0] m);
    case (m)
      MODE_B8:  return (v[DW-1:NW8] == '0) || (&v[DW-1:NW8-1]);
      MODE_B16: return (v[DW-1:NW16] == '0) || (&v[DW-1:NW16-1]);
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/nwx_slice_alu.sv
module nwx_slice_alu
  import nwx_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [2:0]    op_i,
  output logic [DW-1:0] res_o
);
  logic              sub;
  logic [NSLICE-1:0] carry;

  assign sub      = (op_i == OP_SUB);
  assign carry[0] = sub;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    localparam int LO = slice_lo(i);
    localparam int W  = slice_w(i);
    logic [W-1:0] sa, sb, sbx, sum, lres;

    assign sa  = a_i[LO +: W];
    assign sb  = b_i[LO +: W];
    assign sbx = sub ? ~sb : sb;

    if (i < NSLICE - 1) begin : g_chain
      logic [W:0] wide;
      assign wide         = {1'b0, sa} + {1'b0, sbx} + {{W{1'b0}}, carry[i]};
      assign carry[i + 1] = wide[W];
      assign sum          = wide[W-1:0];
    end else begin : g_top
      assign sum = sa + sbx + {{(W-1){1'b0}}, carry[i]};
    end

    always_comb begin
      case (op_i)
        OP_ADD, OP_SUB: lres = sum;
        OP_AND:         lres = sa & sb;
        OP_OR:          lres = sa | sb;
        OP_XOR:         lres = sa ^ sb;
        default:        lres = sa;
      endcase
    end

    assign res_o[LO +: W] = lres;
  end
endmodule

// File: rtl/nwx_width_check.sv
module nwx_width_check
  import nwx_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] res_i,
  input  logic [1:0]    mode_i,
  output logic          fit_o
);
  logic fit_a, fit_b, fit_r;

  assign fit_a = fits_width(a_i, mode_i);
  assign fit_b = fits_width(b_i, mode_i);
  assign fit_r = fits_width(res_i, mode_i);
  assign fit_o = fit_a & fit_b & fit_r;
endmodule

// File: rtl/nwx_mode_ctrl.sv
module nwx_mode_ctrl
  import nwx_pkg::*;
#(
  parameter int PENALTY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              miss_i,
  output logic [1:0]        mode_o,
  output logic              stall_o,
  output logic              replay_fire_o,
  output logic [NSLICE-1:0] slice_en_o,
  output logic [NSLICE-1:0] drowsy_o
);
  localparam int CW = $clog2(PENALTY + 1);

  logic [1:0]  mode_q, mode_d, req_mode;
  logic        wake_q, wake_d, cfg_take;
  logic [CW-1:0] cnt_q, cnt_d;

  assign req_mode = (cfg_mode_i == MODE_RSV) ? MODE_B32 : cfg_mode_i;
  assign cfg_take = cfg_valid_i & ~stall_o;

  always_comb begin
    mode_d = mode_q;
    if (cfg_take)    mode_d = req_mode;
    else if (miss_i) mode_d = MODE_B32;

    wake_d = cfg_take && ((mode_mask(req_mode) & ~mode_mask(mode_q)) != '0);

    cnt_d = cnt_q;
    if (miss_i)            cnt_d = CW'(PENALTY);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_B32;
      wake_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      wake_q <= wake_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o        = mode_q;
  assign replay_fire_o = (cnt_q == CW'(1));
  assign stall_o       = wake_q | (cnt_q != '0);
  assign slice_en_o    = (cnt_q != '0) ? '1 : mode_mask(mode_q);
  assign drowsy_o      = ~slice_en_o;

  // R1: enabled slices always form a contiguous run from the low slice
  a_r1_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_en_o == 3'b001) || (slice_en_o == 3'b011) || (slice_en_o == 3'b111));

  // R4: widening to 32 bits from a narrow mode stalls the following cycle
  a_r4_widen_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid_i && !stall_o && cfg_mode_i == MODE_B32 && mode_q != MODE_B32) |=> stall_o);

  // R9: a misspeculation is followed by a stalled, full-width cycle
  a_r9_penalty_full: assert property (@(posedge clk) disable iff (!rst_n)
    miss_i |=> (stall_o && slice_en_o == 3'b111));
endmodule

// File: rtl/nwx_exec_slice.sv
module nwx_exec_slice
  import nwx_pkg::*;
#(
  parameter int REPLAY_PENALTY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_mode,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     op_b,
  output logic              res_valid,
  output logic [DW-1:0]     res_data,
  output logic [NSLICE-1:0] slice_en,
  output logic [NSLICE-1:0] drowsy,
  output logic              flush_req,
  output logic              stall
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic              accept, miss, fit, replay_fire, res_valid_d;
  logic [1:0]        mode, exe_mode;
  logic [NSLICE-1:0] exe_mask;
  logic [DW-1:0]     alu_a, alu_b, alu_res;
  logic [2:0]        alu_op;
  logic [DW-1:0]     rp_a_q, rp_b_q;
  logic [2:0]        rp_op_q;

  nwx_mode_ctrl #(.PENALTY(REPLAY_PENALTY)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .cfg_valid_i   (cfg_valid),
    .cfg_mode_i    (cfg_mode),
    .miss_i        (miss),
    .mode_o        (mode),
    .stall_o       (stall),
    .replay_fire_o (replay_fire),
    .slice_en_o    (slice_en),
    .drowsy_o      (drowsy)
  );

  assign accept   = op_valid & ~stall;
  assign alu_a    = replay_fire ? rp_a_q  : op_a;
  assign alu_b    = replay_fire ? rp_b_q  : op_b;
  assign alu_op   = replay_fire ? rp_op_q : op_code;
  assign exe_mode = replay_fire ? MODE_B32 : mode;
  assign exe_mask = mode_mask(exe_mode);

  nwx_slice_alu u_alu (
    .a_i   (alu_a),
    .b_i   (alu_b),
    .op_i  (alu_op),
    .res_o (alu_res)
  );

  nwx_width_check u_chk (
    .a_i    (alu_a),
    .b_i    (alu_b),
    .res_i  (alu_res),
    .mode_i (exe_mode),
    .fit_o  (fit)
  );

  assign miss        = accept & ~fit;
  assign res_valid_d = (accept & fit) | replay_fire;

  // replay buffer
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rp_a_q  <= '0;
      rp_b_q  <= '0;
      rp_op_q <= '0;
    end else if (miss) begin
      rp_a_q  <= op_a;
      rp_b_q  <= op_b;
      rp_op_q <= op_code;
    end
  end

  // output control registers
  logic              rv_q, flush_q, ext_q;
  logic [NSLICE-1:0] rmask_q;
  logic [1:0]        rmode_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rv_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      rv_q    <= res_valid_d;
      flush_q <= miss;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ext_q   <= 1'b0;
      rmask_q <= '1;
      rmode_q <= MODE_B32;
    end else if (res_valid_d) begin
      ext_q   <= alu_res[DW-1];
      rmask_q <= exe_mask;
      rmode_q <= exe_mode;
    end
  end

  // per-slice result latches; unused slices are not loaded in narrow modes
  for (genvar i = 0; i < NSLICE; i++) begin : g_rlatch
    localparam int LO = slice_lo(i);
    localparam int W  = slice_w(i);
    logic [W-1:0] q;
    logic         en;

    assign en = res_valid_d & exe_mask[i];

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)  q <= '0;
      else if (en)   q <= alu_res[LO +: W];
    end

    assign res_data[LO +: W] = rmask_q[i] ? q : {W{ext_q}};
  end

  assign res_valid = rv_q;
  assign flush_req = flush_q;

  // R7: a flush never carries a result
  a_r7_flush_no_result: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush_req |-> !res_valid);

  // R7: the flush request is a single-cycle pulse
  a_r7_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush_req |=> !flush_req);

  // R6: every delivered result fits the width it was produced at
  a_r6_result_fits: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_valid |-> fits_width(res_data, rmode_q));

  // R11: nothing is taken while stalled, so a stalled cycle never raises a new flush
  a_r11_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (stall && !replay_fire) |=> !flush_req);
endmodule

// File: tb/nwx_exec_slice_bench.sv
`timescale 1ns/1ps
module nwx_exec_slice_bench;
  localparam int PEN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        res_valid, flush_req, stall;
  logic [31:0] res_data;
  logic [2:0]  slice_en, drowsy;

  int n_cmp = 0;
  int n_bad = 0;
  int cur_w = 32;

  always #2.5 clk = ~clk;

  nwx_exec_slice #(.REPLAY_PENALTY(PEN)) u_nwx_exec_slice (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_mode(cfg_mode),
    .op_valid(op_valid), .op_code(op_code), .op_a(op_a), .op_b(op_b),
    .res_valid(res_valid), .res_data(res_data), .slice_en(slice_en),
    .drowsy(drowsy), .flush_req(flush_req), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int code_w(input logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [2:0] w_mask(input int w);
    return (w == 8) ? 3'b001 : (w == 16) ? 3'b011 : 3'b111;
  endfunction

  function automatic bit ref_fits(input logic [31:0] v, input int w);
    longint unsigned u = longint'(v);
    if (w >= 32) return 1'b1;
    return (u < (64'd1 << w)) || (u >= ((64'd1 << 32) - (64'd1 << (w - 1))));
  endfunction

  function automatic logic [31:0] ref_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return a;
    endcase
  endfunction

  task automatic check_slices(input string req);
    check(slice_en == w_mask(cur_w), {req, " slice_en"}, {29'd0, slice_en}, {29'd0, w_mask(cur_w)});
    check(drowsy == ~slice_en, "R2 drowsy", {29'd0, drowsy}, {29'd0, ~slice_en});
  endtask

  // entered and left just after a falling edge
  task automatic set_mode(input logic [1:0] m);
    int nw = code_w(m);
    bit widen = nw > cur_w;
    cfg_valid = 1'b1; cfg_mode = m;
    @(negedge clk);
    cfg_valid = 1'b0;
    cur_w = nw;
    check(stall == widen, "R4 wake stall", {31'd0, stall}, {31'd0, widen});
    check_slices("R1");
    if (widen) begin
      @(negedge clk);
      check(stall == 1'b0, "R4 single stall", {31'd0, stall}, 32'd0);
    end
  endtask

  // run one op, with an optional reconfiguration in the same cycle
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input bit with_cfg, input logic [1:0] m);
    logic [31:0] exp = ref_res(op, a, b);
    bit fit = ref_fits(a, cur_w) && ref_fits(b, cur_w) && ref_fits(exp, cur_w);
    int after_w = with_cfg ? code_w(m) : (fit ? cur_w : 32);
    op_valid = 1'b1; op_code = op; op_a = a; op_b = b;
    cfg_valid = with_cfg; cfg_mode = m;
    @(negedge clk);
    cfg_valid = 1'b0;
    if (fit) begin
      op_valid = 1'b0;
      check(res_valid && res_data == exp, "R5 result", res_data, exp);
      check(!flush_req, "R6 no flush on fit", {31'd0, flush_req}, 32'd0);
      cur_w = after_w;
      if (with_cfg && after_w > code_w(2'd0) && stall) @(negedge clk);
    end else begin
      check(flush_req && !res_valid, "R7 flush", {30'd0, flush_req, res_valid}, 32'd2);
      check(stall, "R7 stall", {31'd0, stall}, 32'd1);
      check(slice_en == 3'b111, "R9 full width in penalty", {29'd0, slice_en}, 32'd7);
      // junk presented during stall must be ignored (R11)
      op_code = 3'd0; op_a = 32'hDEAD_BEEF; op_b = 32'h1;
      cfg_valid = 1'b1; cfg_mode = 2'd0;
      repeat (PEN - 1) @(negedge clk);
      check(stall && !res_valid, "R7 penalty length", {30'd0, stall, res_valid}, 32'd2);
      @(negedge clk);
      op_valid = 1'b0; cfg_valid = 1'b0;
      check(res_valid && res_data == exp, "R8 replay result", res_data, exp);
      check(!stall, "R8 stall ends", {31'd0, stall}, 32'd0);
      cur_w = after_w;
      check_slices(with_cfg ? "R10" : "R9");
      @(negedge clk);
      check(!res_valid && !flush_req, "R11 stalled op ignored", {30'd0, res_valid, flush_req}, 32'd0);
    end
  endtask

  logic [31:0] pats [12] = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h100,
                             32'h7FFF, 32'hFFFF, 32'hFFFF_FF80, 32'hFFFF_FFFF,
                             32'h1234_5678, 32'hFFFF_8000};

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!res_valid && res_data == 0 && !flush_req && !stall, "R1 reset outputs", res_data, 32'd0);
    check_slices("R1 reset");

    // R4 narrowing then widening
    set_mode(2'd0);
    set_mode(2'd1);
    set_mode(2'd3);

    // R3 + R10: misfit op in 8-bit mode with a 16-bit request in the same cycle
    set_mode(2'd0);
    run_op(3'd0, 32'h100, 32'h0, 1'b1, 2'd1);
    check(slice_en == 3'b011, "R10 mode after replay", {29'd0, slice_en}, 32'd3);

    // R3: fitting op at 32 bits with a narrowing request alongside
    set_mode(2'd2);
    run_op(3'd0, 32'h1234, 32'h0, 1'b1, 2'd0);
    check(slice_en == 3'b001, "R3 new mode next cycle", {29'd0, slice_en}, 32'd1);

    // R9: after a replay the width stays 32 with no reconfiguration
    run_op(3'd0, 32'hFF, 32'h1, 1'b0, 2'd0);
    @(negedge clk);
    check(slice_en == 3'b111, "R9 stays 32", {29'd0, slice_en}, 32'd7);

    // sweep: every width, opcode and operand pair (R5, R6, R7, R8)
    for (int m = 0; m < 3; m++) begin
      for (int op = 0; op < 8; op++) begin
        for (int i = 0; i < 12; i++) begin
          for (int j = 0; j < 12; j++) begin
            if (cur_w != code_w(2'(m))) set_mode(2'(m));
            run_op(3'(op), pats[i], pats[j], 1'b0, 2'd0);
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule